// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is the test access port of a small device. A four-wire serial interface (test clock, mode select, serial data in and out) plus an active-low asynchronous test reset walks a sixteen-state controller. The controller picks between an instruction path and a data path, and moves bits through them one test clock at a time. A two-bit instruction selects which data register sits between the serial input and output: a one-bit bypass stage, a 32-bit identification register, or a short chain of boundary cells. The boundary chain covers the device's inputs and outputs.

The boundary chain serves two purposes. It can take a snapshot of the input pins and of the values being driven on the outputs while the device keeps running. It can also take over the output pads, so that they are driven from preloaded latches for interconnect testing. The block produces the pad-side output values itself, together with the select signal of the output multiplexer. Instructions, pad values and the serial output change on the falling test-clock edge. Capture and shift happen on the rising edge.

Top module: `tap_port`

## Requirements
- R1: With `mode_sel` held high for five rising edges of `test_clk`, the controller reaches its reset state from any state, and entering that state makes the identification register the active instruction (`bsr_drive` low, pads follow `core_out`).
- R2: A low level on `test_rst_n` at once, without a clock, sets the reset state and the identification instruction, drops `scan_out_en` and `bsr_drive`, and returns `pad_out` to `core_out`.
- R3: In the instruction-capture state, the instruction shift stage loads binary 01, so the bits shifted out during an instruction load are 1 then 0 (LSB first).
- R4: A shifted opcode becomes active on the falling `test_clk` edge of the instruction-update state, not on the rising edge that enters it.
- R5: Opcode 00 selects external test, 01 selects sample/preload, 11 selects bypass, and the unused opcode 10 behaves exactly as bypass.
- R6: Under bypass, a single stage that captures 0 sits between `scan_in` and `scan_out`, delaying data by one bit, and `pad_out` equals `core_out`.
- R7: The identification instruction shifts out the 32-bit `ID_CODE`, least significant bit first, with bit 0 forced to 1.
- R8: Under sample/preload, the capture state loads `sys_in` into chain positions 0..N_IN-1 and the current `pad_out` into positions N_IN..N_IN+N_OUT-1. Chain position 0 leaves first. The pads are not disturbed, and the output-cell update latches take the shifted data on the falling edge of the data-update state.
- R9: Under external test, `bsr_drive` is high and `pad_out` is driven from the update latches, independent of `core_out`. A new latch value reaches the pads only on the falling edge of the data-update state.
- R10: `scan_out_en` is high only while the controller is in the instruction-shift or data-shift state, and `scan_out` changes on the falling `test_clk` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| test_clk | input | 1 | Test clock |
| test_rst_n | input | 1 | Asynchronous active-low test reset |
| mode_sel | input | 1 | Controller mode select, sampled on the rising edge |
| scan_in | input | 1 | Serial data into the selected register |
| scan_out | output | 1 | Serial data out, updated on the falling edge |
| scan_out_en | output | 1 | Output enable for `scan_out` (high-impedance when low) |
| sys_in | input | N_IN | Device input pin values seen by the input cells |
| core_out | input | N_OUT | Functional output values from the device core |
| pad_out | output | N_OUT | Values delivered to the output pads |
| bsr_drive | output | 1 | Output multiplexer select: high when the pads come from the update latches |

## Verification
The bench builds the block with two input cells, three output cells and an identification value whose bit 0 is clear. The odd split makes a swapped input/output ordering in the five-cell chain visible. The cleared bit 0 shows whether the forced-one rule is applied. The chain is short enough that every captured and preloaded pattern can be checked bit by bit, including the pad value just before and just after the falling edge of a data update.

// File: rtl/tap_pkg.sv
package tap_pkg;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_DR_SEL, ST_DR_CAP, ST_DR_SHIFT, ST_DR_EXIT1, ST_DR_PAUSE, ST_DR_EXIT2, ST_DR_UPD,
    ST_IR_SEL, ST_IR_CAP, ST_IR_SHIFT, ST_IR_EXIT1, ST_IR_PAUSE, ST_IR_EXIT2, ST_IR_UPD
  } tap_st_t;

  typedef enum logic [1:0] {
    OP_EXT, OP_SAMPLE, OP_IDENT, OP_BYPASS
  } op_t;

  localparam int OPC_W = 2;
  localparam logic [OPC_W-1:0] OPC_CAPTURE = 2'b01;

  function automatic op_t decode_opc(input logic [OPC_W-1:0] code);
    case (code)
      2'b00:   return OP_EXT;
      2'b01:   return OP_SAMPLE;
      default: return OP_BYPASS;
    endcase
  endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
(
  input  logic    test_clk,
  input  logic    test_rst_n,
  input  logic    mode_sel,
  output tap_st_t st
);

  tap_st_t nxt;

  always_comb begin
    case (st)
      ST_RESET:    nxt = mode_sel ? ST_RESET    : ST_IDLE;
      ST_IDLE:     nxt = mode_sel ? ST_DR_SEL   : ST_IDLE;
      ST_DR_SEL:   nxt = mode_sel ? ST_IR_SEL   : ST_DR_CAP;
      ST_DR_CAP:   nxt = mode_sel ? ST_DR_EXIT1 : ST_DR_SHIFT;
      ST_DR_SHIFT: nxt = mode_sel ? ST_DR_EXIT1 : ST_DR_SHIFT;
      ST_DR_EXIT1: nxt = mode_sel ? ST_DR_UPD   : ST_DR_PAUSE;
      ST_DR_PAUSE: nxt = mode_sel ? ST_DR_EXIT2 : ST_DR_PAUSE;
      ST_DR_EXIT2: nxt = mode_sel ? ST_DR_UPD   : ST_DR_SHIFT;
      ST_DR_UPD:   nxt = mode_sel ? ST_DR_SEL   : ST_IDLE;
      ST_IR_SEL:   nxt = mode_sel ? ST_RESET    : ST_IR_CAP;
      ST_IR_CAP:   nxt = mode_sel ? ST_IR_EXIT1 : ST_IR_SHIFT;
      ST_IR_SHIFT: nxt = mode_sel ? ST_IR_EXIT1 : ST_IR_SHIFT;
      ST_IR_EXIT1: nxt = mode_sel ? ST_IR_UPD   : ST_IR_PAUSE;
      ST_IR_PAUSE: nxt = mode_sel ? ST_IR_EXIT2 : ST_IR_PAUSE;
      ST_IR_EXIT2: nxt = mode_sel ? ST_IR_UPD   : ST_IR_SHIFT;
      ST_IR_UPD:   nxt = mode_sel ? ST_DR_SEL   : ST_IDLE;
      default:     nxt = ST_RESET;
    endcase
  end

  always_ff @(posedge test_clk or negedge test_rst_n) begin
    if (!test_rst_n) st <= ST_RESET;
    else             st <= nxt;
  end

  // run of consecutive high mode_sel samples, saturating, for the checker
  localparam int ONES_MAX = 5;
  logic [2:0] ones_cnt;
  always_ff @(posedge test_clk or negedge test_rst_n) begin
    if (!test_rst_n)                  ones_cnt <= '0;
    else if (!mode_sel)               ones_cnt <= '0;
    else if (ones_cnt != 3'(ONES_MAX)) ones_cnt <= ones_cnt + 3'd1;
  end

  // R1
  tlr_reach_chk: assert property (@(posedge test_clk) disable iff (!test_rst_n)
    (mode_sel && ones_cnt >= 3'(ONES_MAX - 1)) |=> (st == ST_RESET));

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_pkg::*;
(
  input  logic    test_clk,
  input  logic    test_rst_n,
  input  tap_st_t st,
  input  logic    scan_in,
  output logic    ir_lsb,
  output op_t     op
);

  logic [OPC_W-1:0] ir_sh;

  always_ff @(posedge test_clk or negedge test_rst_n) begin
    if (!test_rst_n)              ir_sh <= OPC_CAPTURE;
    else if (st == ST_IR_CAP)     ir_sh <= OPC_CAPTURE;
    else if (st == ST_IR_SHIFT)   ir_sh <= {scan_in, ir_sh[OPC_W-1:1]};
  end

  assign ir_lsb = ir_sh[0];

  always_ff @(negedge test_clk or negedge test_rst_n) begin
    if (!test_rst_n)            op <= OP_IDENT;
    else if (st == ST_RESET)    op <= OP_IDENT;
    else if (st == ST_IR_UPD)   op <= decode_opc(ir_sh);
  end

  // R3
  ir_capture_chk: assert property (@(posedge test_clk) disable iff (!test_rst_n)
    (st == ST_IR_CAP) |=> (ir_sh == OPC_CAPTURE));

  // R5
  ir_decode_chk: assert property (@(posedge test_clk) disable iff (!test_rst_n)
    (st == ST_IR_UPD) |=> (op == decode_opc($past(ir_sh))));

endmodule

// File: rtl/tap_bsr.sv
module tap_bsr
  import tap_pkg::*;
#(
  parameter int N_IN  = 3,
  parameter int N_OUT = 3
) (
  input  logic             test_clk,
  input  logic             test_rst_n,
  input  tap_st_t          st,
  input  logic             scan_in,
  input  logic             active,
  input  logic             ext_sel,
  input  logic [N_IN-1:0]  sys_in,
  input  logic [N_OUT-1:0] core_out,
  output logic [N_OUT-1:0] pad_out,
  output logic             chain_lsb
);

  localparam int LEN = N_IN + N_OUT;

  logic [LEN-1:0]   sr;
  logic [LEN:0]     feed;
  logic [LEN-1:0]   cap_vec;
  logic [N_OUT-1:0] upd;

  assign feed    = {scan_in, sr};
  assign cap_vec = {pad_out, sys_in};

  for (genvar g = 0; g < LEN; g++) begin : g_cell
    logic q;
    always_ff @(posedge test_clk or negedge test_rst_n) begin
      if (!test_rst_n)                        q <= 1'b0;
      else if (active && st == ST_DR_CAP)     q <= cap_vec[g];
      else if (active && st == ST_DR_SHIFT)   q <= feed[g+1];
    end
    assign sr[g] = q;
  end

  for (genvar k = 0; k < N_OUT; k++) begin : g_upd
    logic u;
    always_ff @(negedge test_clk or negedge test_rst_n) begin
      if (!test_rst_n)                    u <= 1'b0;
      else if (active && st == ST_DR_UPD) u <= sr[N_IN+k];
    end
    assign upd[k] = u;
  end

  assign pad_out   = ext_sel ? upd : core_out;
  assign chain_lsb = sr[0];

  // R8
  bsr_capture_chk: assert property (@(posedge test_clk) disable iff (!test_rst_n)
    (active && st == ST_DR_CAP) |=> (sr == $past(cap_vec)));

endmodule

// File: rtl/tap_port.sv
module tap_port
  import tap_pkg::*;
#(
  parameter int          N_IN    = 3,
  parameter int          N_OUT   = 3,
  parameter logic [31:0] ID_CODE = 32'h0A5C_3001
) (
  input  logic             test_clk,
  input  logic             test_rst_n,
  input  logic             mode_sel,
  input  logic             scan_in,
  output logic             scan_out,
  output logic             scan_out_en,
  input  logic [N_IN-1:0]  sys_in,
  input  logic [N_OUT-1:0] core_out,
  output logic [N_OUT-1:0] pad_out,
  output logic             bsr_drive
);

  localparam int          ID_W   = 32;
  localparam logic [31:0] ID_VAL = ID_CODE | 32'd1;

  tap_st_t st;
  op_t     op;
  logic    ir_lsb;
  logic    chain_lsb;
  logic    bsr_active;
  logic    byp_q;
  logic [ID_W-1:0] id_sh;
  logic    sel_bit;

  tap_fsm u_fsm (
    .test_clk   (test_clk),
    .test_rst_n (test_rst_n),
    .mode_sel   (mode_sel),
    .st         (st)
  );

  tap_ir u_ir (
    .test_clk   (test_clk),
    .test_rst_n (test_rst_n),
    .st         (st),
    .scan_in    (scan_in),
    .ir_lsb     (ir_lsb),
    .op         (op)
  );

  assign bsr_active = (op == OP_EXT) || (op == OP_SAMPLE);
  assign bsr_drive  = (op == OP_EXT);

  tap_bsr #(.N_IN(N_IN), .N_OUT(N_OUT)) u_bsr (
    .test_clk   (test_clk),
    .test_rst_n (test_rst_n),
    .st         (st),
    .scan_in    (scan_in),
    .active     (bsr_active),
    .ext_sel    (bsr_drive),
    .sys_in     (sys_in),
    .core_out   (core_out),
    .pad_out    (pad_out),
    .chain_lsb  (chain_lsb)
  );

  always_ff @(posedge test_clk or negedge test_rst_n) begin
    if (!test_rst_n)              byp_q <= 1'b0;
    else if (st == ST_DR_CAP)     byp_q <= 1'b0;
    else if (st == ST_DR_SHIFT)   byp_q <= scan_in;
  end

  always_ff @(posedge test_clk or negedge test_rst_n) begin
    if (!test_rst_n)                                id_sh <= ID_VAL;
    else if (op == OP_IDENT && st == ST_DR_CAP)     id_sh <= ID_VAL;
    else if (op == OP_IDENT && st == ST_DR_SHIFT)   id_sh <= {scan_in, id_sh[ID_W-1:1]};
  end

  always_comb begin
    case (op)
      OP_EXT, OP_SAMPLE: sel_bit = chain_lsb;
      OP_IDENT:          sel_bit = id_sh[0];
      default:           sel_bit = byp_q;
    endcase
  end

  always_ff @(negedge test_clk or negedge test_rst_n) begin
    if (!test_rst_n) begin
      scan_out    <= 1'b0;
      scan_out_en <= 1'b0;
    end else begin
      scan_out_en <= (st == ST_IR_SHIFT) || (st == ST_DR_SHIFT);
      if (st == ST_IR_SHIFT)      scan_out <= ir_lsb;
      else if (st == ST_DR_SHIFT) scan_out <= sel_bit;
    end
  end

  // R10
  oe_window_chk: assert property (@(posedge test_clk) disable iff (!test_rst_n)
    scan_out_en |-> (st == ST_IR_SHIFT || st == ST_DR_SHIFT));

  // R10
  oe_missing_chk: assert property (@(posedge test_clk) disable iff (!test_rst_n)
    (st == ST_IR_SHIFT || st == ST_DR_SHIFT) |-> scan_out_en);

endmodule

// File: tb/sim_tap_port.sv
`timescale 1ns/1ps
module sim_tap_port;

  localparam int          N_IN    = 2;
  localparam int          N_OUT   = 3;
  localparam logic [31:0] ID_CODE = 32'h1234_5676;
  localparam logic [31:0] ID_EXP  = 32'h1234_5677;

  logic             test_clk = 1'b0;
  logic             test_rst_n = 1'b1;
  logic             mode_sel = 1'b1;
  logic             scan_in = 1'b0;
  logic             scan_out;
  logic             scan_out_en;
  logic [N_IN-1:0]  sys_in = '0;
  logic [N_OUT-1:0] core_out = 3'b110;
  logic [N_OUT-1:0] pad_out;
  logic             bsr_drive;

  int checks = 0;
  int errors = 0;
  logic  exp_q[$];
  string tag_q[$];

  tap_port #(.N_IN(N_IN), .N_OUT(N_OUT), .ID_CODE(ID_CODE)) u0 (
    .test_clk(test_clk), .test_rst_n(test_rst_n), .mode_sel(mode_sel),
    .scan_in(scan_in), .scan_out(scan_out), .scan_out_en(scan_out_en),
    .sys_in(sys_in), .core_out(core_out), .pad_out(pad_out), .bsr_drive(bsr_drive)
  );

  always #2 test_clk = ~test_clk;

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: scan_out is stable at the rising edge (it moves on the falling one)
  always @(posedge test_clk) begin
    if (test_rst_n && scan_out_en) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R10: actual enable 1 expected 0 (no bit expected)");
      end else begin
        automatic logic  e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (scan_out !== e) begin
          errors++;
          $display("FAIL %s: actual %b expected %b", t, scan_out, e);
        end
      end
    end
  end

  task automatic step(input logic m, input logic d, input logic push,
                      input logic eb, input string tag);
    @(negedge test_clk);
    #1;
    if (push) begin
      exp_q.push_back(eb);
      tag_q.push_back(tag);
    end
    mode_sel = m;
    scan_in  = d;
    @(posedge test_clk);
  endtask

  task automatic shift_ir(input logic [1:0] code, output logic sel_before);
    step(1, 0, 0, 0, "");
    step(1, 0, 0, 0, "");
    step(0, 0, 0, 0, "");
    step(0, 0, 0, 0, "");
    step(0, code[0], 1, 1'b1, "R3");
    step(1, code[1], 1, 1'b0, "R3");
    step(1, 0, 0, 0, "");
    #1 sel_before = bsr_drive;
    step(0, 0, 0, 0, "");
  endtask

  task automatic shift_dr(input int n, input logic [63:0] din, input logic [63:0] exp,
                          input string tag, output logic [N_OUT-1:0] pad_before);
    step(1, 0, 0, 0, "");
    step(0, 0, 0, 0, "");
    step(0, 0, 0, 0, "");
    for (int i = 0; i < n; i++) step(i == n - 1, din[i], 1, exp[i], tag);
    step(1, 0, 0, 0, "");
    #1 pad_before = pad_out;
    step(0, 0, 0, 0, "");
  endtask

  initial begin
    #800000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic sb;
    logic [N_OUT-1:0] pb;
    #1 test_rst_n = 1'b0;
    #6;
    // R2 reset state
    chk(scan_out_en, 0, "R2");
    chk(bsr_drive, 0, "R2");
    chk(pad_out, core_out, "R2");
    @(negedge test_clk);
    test_rst_n = 1'b1;
    step(0, 0, 0, 0, "");
    step(0, 0, 0, 0, "");
    #1 chk(scan_out_en, 0, "R10");

    // R7 identification after reset
    shift_dr(32, 64'd0, {32'd0, ID_EXP}, "R7", pb);

    // R6 bypass (11)
    shift_ir(2'b11, sb);
    shift_dr(4, 64'b1011, 64'b0110, "R6", pb);
    chk(pad_out, core_out, "R6");

    // R5 reserved 10 acts as bypass
    shift_ir(2'b10, sb);
    shift_dr(3, 64'b101, 64'b010, "R5", pb);
    chk(bsr_drive, 0, "R5");

    // R8 sample/preload
    sys_in   = 2'b10;
    core_out = 3'b101;
    shift_ir(2'b01, sb);
    shift_dr(5, 64'b01101, 64'b10110, "R8", pb);
    chk(pad_out, 3'b101, "R8");
    chk(bsr_drive, 0, "R8");

    // R4 / R9 extest
    shift_ir(2'b00, sb);
    chk(sb, 0, "R4");
    chk(bsr_drive, 1, "R4");
    chk(pad_out, 3'b011, "R9");
    core_out = 3'b000;
    #1 chk(pad_out, 3'b011, "R9");
    sys_in = 2'b01;
    shift_dr(5, 64'b10011, 64'b01101, "R9", pb);
    chk(pb, 3'b011, "R9");
    chk(pad_out, 3'b100, "R9");

    // R1 five high samples from the middle of a data shift
    step(1, 0, 0, 0, "");
    step(0, 0, 0, 0, "");
    step(0, 0, 0, 0, "");
    step(1, 0, 1, 1'b1, "R9");
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0, "");
    #1 chk(bsr_drive, 0, "R1");
    chk(pad_out, core_out, "R1");
    step(0, 0, 0, 0, "");
    shift_dr(32, 64'd0, {32'd0, ID_EXP}, "R1", pb);

    // R2 asynchronous reset during extest
    shift_ir(2'b00, sb);
    chk(bsr_drive, 1, "R5");
    @(negedge test_clk);
    #1 test_rst_n = 1'b0;
    #0.5;
    chk(bsr_drive, 0, "R2");
    chk(scan_out_en, 0, "R2");
    chk(pad_out, core_out, "R2");
    @(negedge test_clk);
    #1 test_rst_n = 1'b1;
    step(0, 0, 0, 0, "");
    step(0, 0, 0, 0, "");

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R10: actual %0d pending bits expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule